// File: doc/BRIEF.md
# Jump Target Capability Checker

This block decides whether a control transfer may go ahead, given the capability that governs it. A decode or execute stage presents one request per cycle. Each request carries a jump class, the taken flag of a conditional branch and the target address. It also carries a flag from address translation that marks the target as unusable, and the governing capability: its tag, sealed flag, execute permission and its bounds, given as an inclusive base and an exclusive top. Indirect jumps also supply their 12-bit immediate. One cycle later the block either stays quiet or raises a fault strobe. The strobe carries a 2-bit fault type that identifies a jump/branch fault and a cause code in the 0 to 4 encoding shared with the other capability checks.

The bounds test covers every byte of a minimum-length instruction at the target, not just the first byte. The minimum length is 2 bytes when compressed instructions are enabled and 4 bytes when they are not. The checks that apply, and their priority, depend on the class. Branches test bounds only, and only when they are taken. Direct jumps test the target address and then bounds. Indirect jumps run the full chain: tag, seal, execute permission, address, bounds. For an indirect jump the seal rule fires only when the immediate is nonzero. A small state machine holds the verdict. It has two states: `ST_IDLE`, where no fault is reported, and `ST_FAULT`, where the fault strobe is high for one cycle per faulting request. A request whose verdict is a fault takes the transition `T_RAISE` into `ST_FAULT`, or stays there if already in it. Any cycle without such a request takes `T_CLEAR` back to `ST_IDLE`. Fetching and program-counter update are handled elsewhere.

Top module: `jtc_top`

## Requirements
- R1: After reset the fault strobe is low, the fault type is 2'b00 and the cause is 0.
- R2: The verdict for a request presented with `req_i` high at a clock edge appears on the outputs after that edge and holds for exactly one cycle. A cycle with `req_i` low is followed by a cycle with the fault strobe low.
- R3: A request of class 2'b00 (no jump) never raises a fault, whatever the capability and target inputs.
- R4: A conditional branch (class 2'b01) faults only when `taken_i` is high and the target fails the bounds test, and it then reports cause 4 (bounds). An untaken branch never faults. Tag, seal, permission and the unusable-target flag have no effect on a branch.
- R5: A target passes the bounds test exactly when target ≥ base and target + MIN_LEN ≤ top, with top exclusive. MIN_LEN is 2 when the parameter `COMPRESSED` is 1 and 4 when it is 0.
- R6: A direct jump (class 2'b10) reports cause 3 (invalid address) when `tgt_bad_i` is high and otherwise cause 4 when the target fails the bounds test. Tag, seal and permission have no effect on it.
- R7: An indirect jump (class 2'b11) reports the first of the following that applies, in this order: tag clear (cause 0), sealed with the rule of R8 (cause 1), execute permission clear (cause 2), `tgt_bad_i` high (cause 3), bounds failure (cause 4).
- R8: For an indirect jump, a sealed capability causes a seal fault only when `imm_i` is nonzero. With a zero immediate the seal is ignored and the lower checks decide.
- R9: While the fault strobe is high the fault type is 2'b10 (jump/branch fault) and the cause is at most 4. While the strobe is low the type is 2'b00 and the cause is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 1 | A request is present this cycle |
| cls_i | input | 2 | Jump class: 00 none, 01 branch, 10 direct, 11 indirect |
| taken_i | input | 1 | Branch outcome, used by class 01 only |
| tgt_i | input | AW | Target address |
| tgt_bad_i | input | 1 | Target address marked unusable |
| cap_tag_i | input | 1 | Capability tag is valid |
| cap_sealed_i | input | 1 | Capability is sealed |
| cap_exec_i | input | 1 | Capability grants execute |
| cap_base_i | input | AW | Lowest address in bounds |
| cap_top_i | input | AW+1 | First address above bounds |
| imm_i | input | 12 | Immediate of an indirect jump |
| fault_o | output | 1 | Fault strobe |
| ftype_o | output | 2 | Fault type, 10 for jump/branch faults |
| fcause_o | output | 4 | Fault cause, 0 to 4 |

## Verification
The hardest case to reach from the ports is an indirect jump whose capability is sealed while its immediate is zero. In that case the seal must be skipped, and the outcome must fall through to the permission, address or bounds checks. This only shows when every higher-ranked condition is absent and one lower-ranked condition is present. The stimulus reaches it by holding the tag valid and walking a zero immediate against each lower condition in turn. The same capability is then repeated with a nonzero immediate, so the seal fault wins. The bounds edge is approached a byte at a time at both ends, with the last legal target top − MIN_LEN and the first illegal one top − MIN_LEN + 1. A randomised run then mixes all classes back to back with idle gaps.

// File: rtl/jtc_pkg.sv
package jtc_pkg;

    typedef enum logic [1:0] {
        CLS_NONE     = 2'b00,
        CLS_BRANCH   = 2'b01,
        CLS_DIRECT   = 2'b10,
        CLS_INDIRECT = 2'b11
    } jclass_e;

    typedef enum logic [3:0] {
        CZ_TAG    = 4'd0,
        CZ_SEAL   = 4'd1,
        CZ_PERM   = 4'd2,
        CZ_ADDR   = 4'd3,
        CZ_BOUNDS = 4'd4
    } cause_e;

    localparam logic [1:0] FTYPE_NONE = 2'b00;
    localparam logic [1:0] FTYPE_JUMP = 2'b10;

    typedef struct packed {
        logic   hit;
        cause_e cause;
    } verdict_t;

endpackage

// File: rtl/jtc_span.sv
// Bounds test over every byte of a minimum-length instruction at the target.
module jtc_span #(
    parameter int AW      = 32,
    parameter int MIN_LEN = 2
) (
    input  logic [AW-1:0] tgt_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW:0]   top_i,
    output logic          outside_o
);
    localparam logic [AW:0] LEN_EXT = (AW+1)'(MIN_LEN);

    logic [AW:0] end_excl;

    always_comb begin
        // AW+1 bits: the sum cannot wrap because tgt_i < 2**AW
        end_excl  = {1'b0, tgt_i} + LEN_EXT;
        outside_o = (tgt_i < base_i) || (end_excl > top_i);
    end
endmodule

// File: rtl/jtc_rank.sv
// Per-class fault ordering.
module jtc_rank
    import jtc_pkg::*;
(
    input  jclass_e  cls_i,
    input  logic     taken_i,
    input  logic     tag_i,
    input  logic     sealed_i,
    input  logic     exec_i,
    input  logic     imm_nz_i,
    input  logic     bad_i,
    input  logic     outside_i,
    output verdict_t verdict_o
);
    always_comb begin
        verdict_o = '{hit: 1'b0, cause: CZ_TAG};
        unique case (cls_i)
            CLS_NONE: ;
            CLS_BRANCH: begin
                if (taken_i && outside_i) verdict_o = '{hit: 1'b1, cause: CZ_BOUNDS};
            end
            CLS_DIRECT: begin
                if (bad_i)          verdict_o = '{hit: 1'b1, cause: CZ_ADDR};
                else if (outside_i) verdict_o = '{hit: 1'b1, cause: CZ_BOUNDS};
            end
            CLS_INDIRECT: begin
                if (!tag_i)                    verdict_o = '{hit: 1'b1, cause: CZ_TAG};
                else if (sealed_i && imm_nz_i) verdict_o = '{hit: 1'b1, cause: CZ_SEAL};
                else if (!exec_i)              verdict_o = '{hit: 1'b1, cause: CZ_PERM};
                else if (bad_i)                verdict_o = '{hit: 1'b1, cause: CZ_ADDR};
                else if (outside_i)            verdict_o = '{hit: 1'b1, cause: CZ_BOUNDS};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/jtc_top.sv
module jtc_top
    import jtc_pkg::*;
#(
    parameter int AW         = 32,
    parameter bit COMPRESSED = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_i,
    input  logic [1:0]    cls_i,
    input  logic          taken_i,
    input  logic [AW-1:0] tgt_i,
    input  logic          tgt_bad_i,
    input  logic          cap_tag_i,
    input  logic          cap_sealed_i,
    input  logic          cap_exec_i,
    input  logic [AW-1:0] cap_base_i,
    input  logic [AW:0]   cap_top_i,
    input  logic [11:0]   imm_i,
    output logic          fault_o,
    output logic [1:0]    ftype_o,
    output logic [3:0]    fcause_o
);
    localparam int MIN_LEN = COMPRESSED ? 2 : 4;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FAULT = 1'b1
    } state_e;

    state_e   state_q, state_d;
    cause_e   cause_q, cause_d;
    logic     outside;
    verdict_t verdict;

    jtc_span #(.AW(AW), .MIN_LEN(MIN_LEN)) u_span (
        .tgt_i     (tgt_i),
        .base_i    (cap_base_i),
        .top_i     (cap_top_i),
        .outside_o (outside)
    );

    jtc_rank u_rank (
        .cls_i     (jclass_e'(cls_i)),
        .taken_i   (taken_i),
        .tag_i     (cap_tag_i),
        .sealed_i  (cap_sealed_i),
        .exec_i    (cap_exec_i),
        .imm_nz_i  (|imm_i),
        .bad_i     (tgt_bad_i),
        .outside_i (outside),
        .verdict_o (verdict)
    );

    // Transitions: T_RAISE on a faulting request, T_CLEAR otherwise.
    always_comb begin
        state_d = ST_IDLE;
        cause_d = CZ_TAG;
        unique case (state_q)
            ST_IDLE, ST_FAULT: begin
                if (req_i && verdict.hit) begin
                    state_d = ST_FAULT;
                    cause_d = verdict.cause;
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cause_q <= CZ_TAG;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        fault_o  = 1'b0;
        ftype_o  = FTYPE_NONE;
        fcause_o = 4'd0;
        unique case (state_q)
            ST_IDLE: ;
            ST_FAULT: begin
                fault_o  = 1'b1;
                ftype_o  = FTYPE_JUMP;
                fcause_o = cause_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/jtc_chk.sv
module jtc_chk #(
    parameter int AW = 32
) (
    input logic        clk,
    input logic        rst_n,
    input logic        req_i,
    input logic [1:0]  cls_i,
    input logic        taken_i,
    input logic        tgt_bad_i,
    input logic        cap_tag_i,
    input logic        cap_sealed_i,
    input logic [11:0] imm_i,
    input logic        fault_o,
    input logic [1:0]  ftype_o,
    input logic [3:0]  fcause_o
);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_i |=> !fault_o);
    // R3
    no_jump_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i == 2'b00) |=> !fault_o);
    // R4
    untaken_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i == 2'b01 && !taken_i) |=> !fault_o);
    // R4
    branch_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i == 2'b01) |=> (!fault_o || fcause_o == 4'd4));
    // R6
    direct_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i == 2'b10 && tgt_bad_i) |=> (fault_o && fcause_o == 4'd3));
    // R7
    indirect_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i == 2'b11 && !cap_tag_i) |=> (fault_o && fcause_o == 4'd0));
    // R8
    indirect_seal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i == 2'b11 && cap_tag_i && cap_sealed_i && imm_i != 12'd0)
        |=> (fault_o && fcause_o == 4'd1));
    // R8
    zero_imm_seal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cls_i == 2'b11 && imm_i == 12'd0) |=> fcause_o != 4'd1);
    // R9
    fault_type_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |-> (ftype_o == 2'b10 && fcause_o <= 4'd4));
    // R9
    quiet_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_o |-> (ftype_o == 2'b00 && fcause_o == 4'd0));
endmodule

bind jtc_top jtc_chk #(.AW(AW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_i        (req_i),
    .cls_i        (cls_i),
    .taken_i      (taken_i),
    .tgt_bad_i    (tgt_bad_i),
    .cap_tag_i    (cap_tag_i),
    .cap_sealed_i (cap_sealed_i),
    .imm_i        (imm_i),
    .fault_o      (fault_o),
    .ftype_o      (ftype_o),
    .fcause_o     (fcause_o)
);

// File: tb/sim_jtc_top.sv
`timescale 1ns/1ps
module sim_jtc_top;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_i = 1'b0;
    logic [1:0]    cls_i = 2'b00;
    logic          taken_i = 1'b0;
    logic [AW-1:0] tgt_i = '0;
    logic          tgt_bad_i = 1'b0;
    logic          cap_tag_i = 1'b0;
    logic          cap_sealed_i = 1'b0;
    logic          cap_exec_i = 1'b0;
    logic [AW-1:0] cap_base_i = '0;
    logic [AW:0]   cap_top_i = '0;
    logic [11:0]   imm_i = '0;
    logic          fault_o;
    logic [1:0]    ftype_o;
    logic [3:0]    fcause_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [4:0] exp_q[$];
    string      lbl_q[$];
    logic       mon_pend;

    always #2 clk = ~clk;

    jtc_top #(.AW(AW), .COMPRESSED(1'b1)) u0 (.*);

    // R5: MIN_LEN is 2 with COMPRESSED = 1
    function automatic logic [4:0] model(input logic [1:0] c, input logic tk,
        input logic [AW-1:0] t, input logic bd, input logic tg, input logic sl,
        input logic ex, input logic [AW-1:0] b, input logic [AW:0] tp, input logic [11:0] im);
        logic oob;
        oob = (t < b) || (({1'b0, t} + 33'd2) > tp);
        case (c)
            2'b01:   return (tk && oob) ? 5'h14 : 5'h00;
            2'b10:   return bd ? 5'h13 : (oob ? 5'h14 : 5'h00);
            2'b11: begin
                if (!tg)                return 5'h10;
                if (sl && im != 12'd0)  return 5'h11;
                if (!ex)                return 5'h12;
                if (bd)                 return 5'h13;
                if (oob)                return 5'h14;
                return 5'h00;
            end
            default: return 5'h00;
        endcase
    endfunction

    task automatic check(input bit ok, input string rq, input string act, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%s expected=%s", rq, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] c, input logic tk, input logic [AW-1:0] t,
        input logic bd, input logic tg, input logic sl, input logic ex,
        input logic [AW-1:0] b, input logic [AW:0] tp, input logic [11:0] im, input string rq);
        @(negedge clk);
        req_i = 1'b1; cls_i = c; taken_i = tk; tgt_i = t; tgt_bad_i = bd;
        cap_tag_i = tg; cap_sealed_i = sl; cap_exec_i = ex;
        cap_base_i = b; cap_top_i = tp; imm_i = im;
        exp_q.push_back(model(c, tk, t, bd, tg, sl, ex, b, tp, im));
        lbl_q.push_back(rq);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_i = 1'b0;
        end
    endtask

    // Monitor: scoreboard pop one cycle after each request
    always @(posedge clk) begin
        mon_pend = req_i && rst_n;
        #1;
        if (mon_pend) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "result", "empty queue");
            end else begin
                logic [4:0] e;
                string      l;
                logic [1:0] et;
                logic [3:0] ec;
                e = exp_q.pop_front();
                l = lbl_q.pop_front();
                et = e[4] ? 2'b10 : 2'b00;
                ec = e[4] ? e[3:0] : 4'd0;
                // R9 type and cause fields
                check(fault_o == e[4] && ftype_o == et && fcause_o == ec, l,
                    $sformatf("f=%0b t=%0d c=%0d", fault_o, ftype_o, fcause_o),
                    $sformatf("f=%0b t=%0d c=%0d", e[4], et, ec));
            end
        end else if (rst_n) begin
            if (fault_o !== 1'b0)
                check(1'b0, "R2", $sformatf("f=%0b", fault_o), "f=0");
        end
    end

    localparam logic [AW-1:0] B = 32'h1000;
    localparam logic [AW:0]   T = 33'h2000;

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(fault_o == 1'b0 && ftype_o == 2'b00 && fcause_o == 4'd0, "R1",
            $sformatf("f=%0b t=%0d c=%0d", fault_o, ftype_o, fcause_o), "f=0 t=0 c=0");
        rst_n = 1'b1;
        idle(2);
        // R3 no-jump class with every fault source active
        drive(2'b00, 1, 32'h5, 1, 0, 1, 0, B, T, 12'h7, "R3");
        // R4 untaken branch out of bounds
        drive(2'b01, 0, 32'h3000, 0, 1, 0, 1, B, T, 0, "R4");
        // R5 last legal target, first illegal, below base, exactly base
        drive(2'b01, 1, 32'h1FFE, 0, 1, 0, 1, B, T, 0, "R5");
        drive(2'b01, 1, 32'h1FFF, 0, 1, 0, 1, B, T, 0, "R5");
        drive(2'b01, 1, 32'h0FFF, 0, 1, 0, 1, B, T, 0, "R5");
        drive(2'b01, 1, 32'h1000, 0, 1, 0, 1, B, T, 0, "R5");
        // R4 branch ignores tag, seal, perm, bad address
        drive(2'b01, 1, 32'h1800, 1, 0, 1, 0, B, T, 12'h1, "R4");
        idle(1);
        // R6 direct: address before bounds, bounds, ignores capability bits
        drive(2'b10, 1, 32'h3000, 1, 1, 0, 1, B, T, 0, "R6");
        drive(2'b10, 1, 32'h1FFF, 0, 0, 1, 0, B, T, 0, "R6");
        drive(2'b10, 1, 32'h1800, 0, 0, 1, 0, B, T, 12'h3, "R6");
        // R7 priority chain, peeling one condition at a time
        drive(2'b11, 1, 32'h3000, 1, 0, 1, 0, B, T, 12'h5, "R7");
        drive(2'b11, 1, 32'h3000, 1, 1, 1, 0, B, T, 12'h5, "R7");
        drive(2'b11, 1, 32'h3000, 1, 1, 0, 0, B, T, 12'h5, "R7");
        drive(2'b11, 1, 32'h3000, 1, 1, 0, 1, B, T, 12'h5, "R7");
        drive(2'b11, 1, 32'h3000, 0, 1, 0, 1, B, T, 12'h5, "R7");
        drive(2'b11, 1, 32'h1800, 0, 1, 0, 1, B, T, 12'h5, "R7");
        // R8 sealed with zero immediate falls through
        drive(2'b11, 1, 32'h1800, 0, 1, 1, 0, B, T, 12'h0, "R8");
        drive(2'b11, 1, 32'h1800, 1, 1, 1, 1, B, T, 12'h0, "R8");
        drive(2'b11, 1, 32'h1FFF, 0, 1, 1, 1, B, T, 12'h0, "R8");
        drive(2'b11, 1, 32'h1800, 0, 1, 1, 1, B, T, 12'h0, "R8");
        drive(2'b11, 1, 32'h1800, 0, 1, 1, 1, B, T, 12'h800, "R8");
        idle(2);
        // R7 R4 R6 mixed random traffic
        for (int i = 0; i < 200; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (r[31:29] == 3'd0) idle(1);
            drive(r[1:0], r[2], 32'h0FF0 + (r[27:16] % 32'h1020), r[3], r[4], r[5], r[6],
                B, T, r[7] ? 12'h0 : {4'h0, r[15:8]}, "R7");
        end
        idle(3);
        check(exp_q.size() == 0, "R2", $sformatf("left=%0d", exp_q.size()), "left=0");
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #400000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule